// File: doc/BRIEF.md
# Serial Memory Bus Slave with Two Type Identifiers

This block is the bus-side front end of a small serial memory. It samples the two-wire bus (clock line and data line) with the system clock and recognises Start and Stop conditions on resynchronised copies of both lines. After each Start it shifts in an 8-bit select byte. The upper nibble of that byte is compared against two type identifiers. One identifier sends the transfer to the byte-wide memory port, the other sends it to the protection-register port. Any other value leaves the slave silent until the next Start.

For a memory write, the first byte after the select byte loads the internal address. Every later byte produces a one-cycle write strobe, and the address then advances. A memory read starts at the current address. Each byte the master acknowledges advances the address and loads the next byte. The protection register takes one write strobe per received byte and returns its value on reads. The data line is modelled as an active-low drive enable plus a sampled input. While the lockout input is high, the bus is ignored completely.

Top module: `i2c_dual_select_slave`

## Requirements
- R1: A Start is a falling data line while the clock line is high, as seen on the synchronised lines. It restarts select-byte reception from any state, including the middle of a byte.
- R2: A select byte whose bits [7:4] are 1010 targets the memory. The slave pulls the data line low (`sda_drive_n` = 0) for the 9th clock.
- R3: A select byte whose bits [7:4] are 0110 targets the protection register and is acknowledged in the same way. Bit [0] = 1 selects a read.
- R4: A select byte whose bits [7:4] match neither identifier is not acknowledged. The slave ignores every following byte until the next Start.
- R5: In a memory write, the first byte sets `mem_addr`. Each later byte gives a single-cycle `mem_wr_en` with `wr_data` at the current `mem_addr`. The address then increments and wraps from 2^ADDR_W-1 to 0.
- R6: In a protection-register write, every received byte gives a single-cycle `prot_wr_en` with that byte on `wr_data`. Each such byte is acknowledged.
- R7: In a read, the slave sends the byte most significant bit first and releases the data line in the 9th clock. Its drive changes only while the synchronised clock is low, except when a Start, a Stop or the lockout forces a release.
- R8: If the master acknowledges a memory read byte, the address increments and the next byte is sent. After a NoAck the slave stays released, keeps its address, and waits for a Start.
- R9: While `por_hold` is high, the slave drives nothing, issues no strobes, and returns to idle. A Start that is detected during the lockout is lost.
- R10: A Stop (a rising data line while the clock is high) returns the slave to idle. Bytes clocked in after it without a new Start are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| por_hold | input | 1 | Lockout; high ignores the bus |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_n | output | 1 | 0 pulls the data line low, 1 releases it |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_en | output | 1 | One-cycle pulse when a memory byte is loaded for sending |
| mem_rdata | input | 8 | Memory read data for `mem_addr` |
| mem_wr_en | output | 1 | One-cycle memory write strobe |
| wr_data | output | 8 | Write data for either target |
| prot_wr_en | output | 1 | One-cycle protection-register write strobe |
| prot_rdata | input | 8 | Current protection-register value |

## Verification
A clock edge detected on the bus can coincide with the end of the power-on lockout. This matters most when the lockout ends just as a Start reaches the condition detector. The bench drops `por_hold` either before or after the cycle in which the synchronised data fall is detected. In the first case the select byte that follows must be acknowledged; in the second it must be ignored. A cycle-accurate reference model in the bench is compared with `sda_drive_n` and the strobes on every clock, and the transaction-level outcome is also checked.

// File: rtl/i2cds_pkg.sv
// Package: shared types for the dual-identifier bus slave.
// Assumes: one byte per bus transfer.
package i2cds_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_ACK   = 3'd2,
        ST_RX    = 3'd3,
        ST_TX    = 3'd4,
        ST_ACKIN = 3'd5
    } eng_state_t;

    typedef enum logic {
        TGT_MEM  = 1'b0,
        TGT_PROT = 1'b1
    } target_t;
endpackage

// File: rtl/i2cds_line_sync.sv
// Module: resynchronises the clock and data lines and flags edges and bus conditions.
// Assumes: both lines idle high; the bus is at least several system clocks per phase.
module i2cds_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Shift chain: brings one line into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // History register: previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2cds_sel_decode.sv
// Module: compares the upper nibble of a select byte with the two type identifiers.
// Assumes: the identifiers differ.
module i2cds_sel_decode #(
    parameter logic [3:0] MEM_ID  = 4'b1010,
    parameter logic [3:0] PROT_ID = 4'b0110
) (
    input  logic [7:0] sel_byte,
    output logic       hit_mem,
    output logic       hit_prot
);
    // Identifier compare on bits [7:4].
    always_comb begin
        hit_mem  = (sel_byte[7:4] == MEM_ID);
        hit_prot = (sel_byte[7:4] == PROT_ID);
    end
endmodule

// File: rtl/i2cds_engine.sv
// Module: bit and byte sequencer. It receives the select byte, acknowledges,
// receives or sends data, and drives the memory and protection ports.
// Assumes: edges and conditions come pre-synchronised from i2cds_line_sync.
module i2cds_engine
    import i2cds_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              hit_mem,
    input  logic              hit_prot,
    output logic [BYTE_W-1:0] shreg,
    output logic              sda_drive_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              prot_wr_en,
    input  logic [BYTE_W-1:0] prot_rdata
);
    eng_state_t        st;
    target_t           tgt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              is_read;
    logic              first_byte;
    logic              inc_pend;
    logic              master_ack;
    logic [BYTE_W-1:0] rd_byte;

    // Read source: pick the byte for the addressed target.
    always_comb rd_byte = (tgt == TGT_PROT) ? prot_rdata : mem_rdata;

    // Sequencer: one state step per synchronised bus event.
    always_ff @(posedge clk) begin
        if (!rst_n || lockout) begin
            st          <= ST_IDLE;
            tgt         <= TGT_MEM;
            bit_cnt     <= '0;
            shreg       <= '0;
            is_read     <= 1'b0;
            first_byte  <= 1'b0;
            inc_pend    <= 1'b0;
            master_ack  <= 1'b0;
            sda_drive_n <= 1'b1;
            mem_rd_en   <= 1'b0;
            mem_wr_en   <= 1'b0;
            prot_wr_en  <= 1'b0;
            if (!rst_n) begin
                mem_addr <= '0;
                wr_data  <= '0;
            end
        end else begin
            mem_rd_en  <= 1'b0;
            mem_wr_en  <= 1'b0;
            prot_wr_en <= 1'b0;
            if (start_det) begin
                st          <= ST_SEL;
                bit_cnt     <= '0;
                sda_drive_n <= 1'b1;
            end else if (stop_det) begin
                st          <= ST_IDLE;
                sda_drive_n <= 1'b1;
            end else begin
                case (st)
                    ST_SEL: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            if (hit_mem || hit_prot) begin
                                tgt         <= hit_prot ? TGT_PROT : TGT_MEM;
                                is_read     <= shreg[0];
                                first_byte  <= 1'b1;
                                sda_drive_n <= 1'b0;
                                st          <= ST_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt  <= '0;
                            inc_pend <= 1'b0;
                            if (inc_pend) mem_addr <= mem_addr + 1'b1;
                            if (is_read) begin
                                shreg       <= rd_byte;
                                sda_drive_n <= rd_byte[BYTE_W-1];
                                mem_rd_en   <= (tgt == TGT_MEM);
                                st          <= ST_TX;
                            end else begin
                                sda_drive_n <= 1'b1;
                                st          <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            sda_drive_n <= 1'b0;
                            st          <= ST_ACK;
                            wr_data     <= shreg;
                            if (tgt == TGT_PROT) begin
                                prot_wr_en <= 1'b1;
                            end else if (first_byte) begin
                                mem_addr   <= ADDR_W'(shreg);
                                first_byte <= 1'b0;
                            end else begin
                                mem_wr_en <= 1'b1;
                                inc_pend  <= 1'b1;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_drive_n <= 1'b1;
                                st          <= ST_ACKIN;
                            end else begin
                                shreg       <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_drive_n <= shreg[BYTE_W-2];
                                bit_cnt     <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACKIN: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_s;
                            if (!sda_s && tgt == TGT_MEM) mem_addr <= mem_addr + 1'b1;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                bit_cnt     <= '0;
                                shreg       <= rd_byte;
                                sda_drive_n <= rd_byte[BYTE_W-1];
                                mem_rd_en   <= (tgt == TGT_MEM);
                                st          <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: no drive and no strobes in the cycle after the lockout is seen.
    a_r9_lockout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (sda_drive_n && !mem_wr_en && !prot_wr_en && !mem_rd_en));

    // R7: the drive only moves on a low clock unless a condition or the lockout forced it.
    a_r7_drive_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_n) && !$past(start_det) && !$past(stop_det) && !$past(lockout))
        |-> !$past(scl_s));

    // R5: a memory write strobe lasts one cycle.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    // R4: an unknown identifier returns to idle with the line released.
    a_r4_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEL && scl_fall && bit_cnt == CNT_W'(BYTE_W) && !hit_mem && !hit_prot
         && !start_det && !stop_det && !lockout) |=> (st == ST_IDLE && sda_drive_n));

    // R8: the slave never drives while the master acknowledges.
    a_r8_release_master_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACKIN) |-> sda_drive_n);

    // R6: only one target is strobed in a cycle.
    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && prot_wr_en));
endmodule

// File: rtl/i2c_dual_select_slave.sv
// Module: top of the bus slave. It connects line synchronisation, identifier decode
// and the sequencer.
// Assumes: sda_i is the wired line, including this slave's own pull-down.
module i2c_dual_select_slave #(
    parameter int         ADDR_W  = 8,
    parameter logic [3:0] MEM_ID  = 4'b1010,
    parameter logic [3:0] PROT_ID = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_hold,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        wr_data,
    output logic              prot_wr_en,
    input  logic [7:0]        prot_rdata
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       hit_mem, hit_prot;
    logic [7:0] shreg;

    i2cds_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cds_sel_decode #(.MEM_ID(MEM_ID), .PROT_ID(PROT_ID)) u_dec (
        .sel_byte(shreg), .hit_mem(hit_mem), .hit_prot(hit_prot)
    );

    i2cds_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .lockout(por_hold),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .hit_mem(hit_mem), .hit_prot(hit_prot), .shreg(shreg),
        .sda_drive_n(sda_drive_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .wr_data(wr_data),
        .prot_wr_en(prot_wr_en), .prot_rdata(prot_rdata)
    );
endmodule

// File: tb/test_i2c_dual_select_slave.sv
module test_i2c_dual_select_slave;
    localparam int Q = 3;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_hold = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_drive_n, mem_rd_en, mem_wr_en, prot_wr_en;
    logic [7:0] mem_addr, wr_data, mem_rdata, prot_rdata;
    logic [7:0] bmem [256];
    logic [7:0] bprot = 8'h00;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus    = sda_m & sda_drive_n;
    assign mem_rdata  = bmem[mem_addr];
    assign prot_rdata = bprot;

    i2c_dual_select_slave i_i2c_dual_select_slave (
        .clk(clk), .rst_n(rst_n), .por_hold(por_hold), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_n(sda_drive_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .wr_data(wr_data),
        .prot_wr_en(prot_wr_en), .prot_rdata(prot_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 7 + 3);
    endfunction

    // Storage behind the ports, updated from the design's strobes.
    initial for (int i = 0; i < 256; i++) bmem[i] = init_val(i);
    always @(posedge clk) begin
        if (mem_wr_en)  bmem[mem_addr] <= wr_data;
        if (prot_wr_en) bprot <= wr_data;
    end

    // Reference model: cycle-level behaviour from the requirements, integer phases.
    int  m_ph = 0, m_cnt = 0, m_addr = 0;
    bit  m_drv = 1, m_wr = 0, m_pw = 0, m_rd = 0, m_read = 0, m_prot = 0, m_first = 0;
    bit  m_inc = 0, m_mack = 0;
    logic [7:0] m_sh = 0, m_wd = 0, m_ld;
    bit  q_scl [3];
    bit  q_sda [3];
    always @(posedge clk) begin
        bit rs, rd, rise, fall, st, sp;
        rs = scl_m; rd = sda_m & m_drv;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin q_scl[k] = 1; q_sda[k] = 1; end
            m_ph = 0; m_cnt = 0; m_addr = 0; m_drv = 1; m_wr = 0; m_pw = 0; m_rd = 0;
            m_sh = 0; m_wd = 0; m_inc = 0; m_mack = 0; m_first = 0; m_read = 0; m_prot = 0;
        end else begin
            rise = q_scl[1] && !q_scl[2];
            fall = !q_scl[1] && q_scl[2];
            st = q_scl[1] && q_scl[2] && q_sda[2] && !q_sda[1];
            sp = q_scl[1] && q_scl[2] && !q_sda[2] && q_sda[1];
            m_wr = 0; m_pw = 0; m_rd = 0;
            if (por_hold) begin
                m_ph = 0; m_cnt = 0; m_drv = 1; m_sh = 0; m_inc = 0; m_mack = 0;
                m_first = 0; m_read = 0; m_prot = 0;
            end else if (st) begin m_ph = 1; m_cnt = 0; m_drv = 1; end
            else if (sp) begin m_ph = 0; m_drv = 1; end
            else if ((m_ph == 1 || m_ph == 3) && rise) begin
                m_sh = {m_sh[6:0], q_sda[1]}; m_cnt++;
            end else if (m_ph == 1 && fall && m_cnt == 8) begin
                if (m_sh[7:4] == 4'b1010 || m_sh[7:4] == 4'b0110) begin
                    m_prot = (m_sh[7:4] == 4'b0110); m_read = m_sh[0];
                    m_first = 1; m_drv = 0; m_ph = 2;
                end else m_ph = 0;
            end else if (m_ph == 2 && fall) begin
                m_cnt = 0;
                if (m_inc) m_addr = (m_addr + 1) % 256;
                m_inc = 0;
                if (m_read) begin
                    m_ld = m_prot ? bprot : bmem[m_addr];
                    m_sh = m_ld; m_drv = m_ld[7]; m_rd = !m_prot; m_ph = 4;
                end else begin m_drv = 1; m_ph = 3; end
            end else if (m_ph == 3 && fall && m_cnt == 8) begin
                m_drv = 0; m_ph = 2; m_wd = m_sh;
                if (m_prot) m_pw = 1;
                else if (m_first) begin m_addr = m_sh; m_first = 0; end
                else begin m_wr = 1; m_inc = 1; end
            end else if (m_ph == 4 && fall) begin
                if (m_cnt == 7) begin m_drv = 1; m_ph = 5; end
                else begin m_drv = m_sh[6]; m_sh = {m_sh[6:0], 1'b0}; m_cnt++; end
            end else if (m_ph == 5 && rise) begin
                m_mack = !q_sda[1];
                if (!q_sda[1] && !m_prot) m_addr = (m_addr + 1) % 256;
            end else if (m_ph == 5 && fall) begin
                if (m_mack) begin
                    m_ld = m_prot ? bprot : bmem[m_addr];
                    m_cnt = 0; m_sh = m_ld; m_drv = m_ld[7]; m_rd = !m_prot; m_ph = 4;
                end else m_ph = 0;
            end
            q_scl[2] = q_scl[1]; q_scl[1] = q_scl[0]; q_scl[0] = rs;
            q_sda[2] = q_sda[1]; q_sda[1] = q_sda[0]; q_sda[0] = rd;
        end
    end

    // Per-clock comparison of the outputs with the model (R5 R7 R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (sda_drive_n !== m_drv || mem_wr_en !== m_wr || prot_wr_en !== m_pw ||
                mem_rd_en !== m_rd || mem_addr !== 8'(m_addr) ||
                ((m_wr || m_pw) && wr_data !== m_wd)) begin
                n_bad++;
                $display("FAIL R7 cycle compare t=%0t: drv/wr/pw/rd/addr/wd act %b%b%b%b %h %h exp %b%b%b%b %h %h",
                    $time, sda_drive_n, mem_wr_en, prot_wr_en, mem_rd_en, mem_addr, wr_data,
                    m_drv, m_wr, m_pw, m_rd, 8'(m_addr), m_wd);
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1; cyc(Q); scl_m = 1; cyc(H); sda_m = 0; cyc(H); scl_m = 0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; cyc(Q); scl_m = 1; cyc(H); sda_m = 1; cyc(H);
    endtask

    task automatic send_bit(bit b);
        sda_m = b; cyc(Q); scl_m = 1; cyc(H); scl_m = 0; cyc(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1; cyc(Q); scl_m = 1; cyc(H / 2); ack = sda_bus; cyc(H - H / 2);
        scl_m = 0; cyc(Q);
    endtask

    task automatic recv_byte(bit nack, output logic [7:0] v);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            cyc(Q); scl_m = 1; cyc(H / 2); v[i] = sda_bus; cyc(H - H / 2); scl_m = 0; cyc(Q);
        end
        send_bit(nack);
    endtask

    // Stimulus and transaction-level checks.
    initial begin
        bit a;
        logic [7:0] d;
        cyc(6);
        rst_n = 1;
        cyc(4);
        check(sda_drive_n === 1'b1 && mem_wr_en === 1'b0 && prot_wr_en === 1'b0, "R9 reset state",
              {sda_drive_n, mem_wr_en, prot_wr_en}, 3'b100);

        // R2 R5: memory write with address byte.
        bus_start(); send_byte(8'hA0, a); check(a == 0, "R2 memory select ack", a, 0);
        send_byte(8'h10, a); send_byte(8'h5A, a); send_byte(8'hC3, a); bus_stop();
        check(bmem[8'h10] == 8'h5A, "R5 write first", bmem[8'h10], 8'h5A);
        check(bmem[8'h11] == 8'hC3, "R5 write incremented", bmem[8'h11], 8'hC3);

        // R7 R8: random read with master ack then NoAck.
        bus_start(); send_byte(8'hA0, a); send_byte(8'h10, a);
        bus_start(); send_byte(8'hA1, a); check(a == 0, "R2 read select ack", a, 0);
        recv_byte(0, d); check(d == 8'h5A, "R7 read msb first", d, 8'h5A);
        recv_byte(1, d); check(d == 8'hC3, "R8 next after ack", d, 8'hC3);
        bus_stop();
        bus_start(); send_byte(8'hA1, a); recv_byte(1, d); bus_stop();
        check(d == 8'hC3, "R8 no increment after NoAck", d, 8'hC3);

        // R5: address wrap.
        bus_start(); send_byte(8'hA0, a); send_byte(8'hFE, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
        check(bmem[8'hFF] == 8'h22, "R5 top address", bmem[8'hFF], 8'h22);
        check(bmem[8'h00] == 8'h33, "R5 wrap to zero", bmem[8'h00], 8'h33);

        // R3 R6: protection register.
        bus_start(); send_byte(8'h60, a); check(a == 0, "R3 prot select ack", a, 0);
        send_byte(8'h3C, a); check(a == 0, "R6 prot byte ack", a, 0); bus_stop();
        check(bprot == 8'h3C, "R6 prot written", bprot, 8'h3C);
        bus_start(); send_byte(8'h61, a); recv_byte(1, d); bus_stop();
        check(d == 8'h3C, "R3 prot read", d, 8'h3C);

        // R4: unknown identifier.
        bus_start(); send_byte(8'hB0, a); check(a == 1, "R4 no ack unknown id", a, 1);
        send_byte(8'h20, a); check(a == 1, "R4 later byte ignored", a, 1); bus_stop();

        // R1: Start in the middle of a byte.
        bus_start(); send_bit(1); send_bit(1); send_bit(0); send_bit(1);
        bus_start(); send_byte(8'hA0, a); check(a == 0, "R1 restart ack", a, 0);
        send_byte(8'h40, a); send_byte(8'h99, a); bus_stop();
        check(bmem[8'h40] == 8'h99, "R1 write after restart", bmem[8'h40], 8'h99);

        // R10: bytes after a Stop without a new Start.
        bus_start(); send_byte(8'hA0, a); send_byte(8'h50, a); bus_stop();
        scl_m = 0; cyc(Q);
        send_byte(8'h77, a); check(a == 1, "R10 no ack after stop", a, 1);
        bus_stop();
        check(bmem[8'h50] == init_val(8'h50), "R10 memory unchanged", bmem[8'h50], init_val(8'h50));

        // R9: lockout.
        por_hold = 1;
        bus_start(); send_byte(8'hA0, a); check(a == 1, "R9 no ack under lockout", a, 1);
        send_byte(8'h60, a); send_byte(8'h88, a); bus_stop();
        check(bmem[8'h61] == init_val(8'h61), "R9 no write under lockout", bmem[8'h61], init_val(8'h61));
        // R9: lockout still high when the Start is detected: Start lost.
        sda_m = 0; cyc(3); por_hold = 0; cyc(H); scl_m = 0; cyc(Q);
        send_byte(8'hA0, a); check(a == 1, "R9 start lost at lockout edge", a, 1); bus_stop();
        // R9: lockout released before detection: Start taken.
        por_hold = 1; cyc(Q);
        sda_m = 0; cyc(1); por_hold = 0; cyc(H); scl_m = 0; cyc(Q);
        send_byte(8'hA0, a); check(a == 0, "R9 start taken after release", a, 0); bus_stop();
        cyc(10);
        done = 1;
    end

    // Watchdog.
    initial begin
        int t;
        for (t = 0; t < 150000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete");
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule